// File: doc/BRIEF.md
# Serial-controlled digital potentiometer command decoder

This block is the control side of a digitally controlled potentiometer behind an SPI slave port. It keeps one 10-bit wiper counter (WCR) and four 10-bit data registers. A host selects the block by pulling chip select low and then shifts in frames on the serial input. Frames are either two or four bytes long, depending on the opcode. The first byte must carry the fixed identifier nibble 0101 followed by the block's address nibble. If it does not, the frame is dropped until chip select returns high. Read commands return their result in the last two bytes on the serial output. An output-enable says when that output is being driven.

Changes to the wiper counter reach the `wiper_o` port after a fixed settling delay of `WRL_CYC` clock cycles. A write of a data register, or a copy of the wiper into one, models a nonvolatile write. It starts only when chip select rises after a frame of exactly the right length. It keeps a write-in-progress flag (WIP) set for `NV_CYC` cycles, and the host can poll that flag with a status read. The serial pins are oversampled in the system clock domain, so SCK must stay well below the clock rate. A phase of at least four clock cycles is enough.

Top module: `dcp_spi_top`

## Requirements
- R1: After reset `wiper_o` is 0, `so_oe_o` is 0, the WCR and all four data registers read back 0, and WIP reads 0.
- R2: Byte 0 is sent MSB first as {4'b0101, address nibble}, and the address nibble must equal `DEV_ADDR`. A frame whose byte 0 does not match changes no register and never drives the serial output.
- R3: Byte 1 is {opcode[2:0], 3'b000, select[1:0]}. In four-byte frames, bytes 2 and 3 form a 16-bit word {6 padding bits, value[9:0]}, sent MSB first. Opcode 2 loads the WCR from that value, and the padding bits are ignored. For opcode 1, the WCR is returned in that same layout with zero padding. Input is sampled on SCK rising edges and output changes after SCK falling edges.
- R4: `wiper_o` takes the new WCR value exactly `WRL_CYC` clock cycles after the WCR changes. With the default parameters this is the 8th clock cycle after chip select rises at the end of the frame.
- R5: Opcode 4 writes the frame's value into data register `select`. The register keeps its old contents while WIP is 1, which lasts `NV_CYC` cycles, and holds the new value afterwards. Opcode 3 reads data register `select`.
- R6: Opcode 5 is a four-byte status read. It returns WIP in bit 0 of the 16-bit reply word, and all other reply bits are 0.
- R7: Opcode 6 is a two-byte frame that copies data register `select` into the WCR.
- R8: Opcode 7 is a two-byte frame that copies the WCR into data register `select` as a nonvolatile write with WIP, as in R5.
- R9: A write or transfer takes effect only when chip select rises and the bit count equals the opcode's frame length: 16 bits for opcodes 6 and 7, 32 for the others. A shorter frame has no effect.
- R10: A write or transfer frame that completes while WIP is 1 is ignored. Status reads are still answered.
- R11: Opcode 0 is a no-op. `so_oe_o` is 1 only during the 16 reply bits of a valid read frame (opcodes 1, 3, 5) and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | High while `so_o` is driven |
| wiper_o | output | 10 | Settled wiper position |

## Verification
A wrong bit counter or a stale opcode shows up at the serial output of the very next read frame. The reply would be misaligned by a bit, the output-enable window would be wrong, or a truncated frame would be committed. A busy counter of the wrong length makes WIP or the data register contents differ on reads taken a few hundred cycles into the busy window, or right after it ends. A wrong settling counter moves the `wiper_o` change away from the exact clock cycle set in R4, which the bench checks on both sides.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int WCR_W  = 10;
  localparam int NDR    = 4;
  localparam int SEL_W  = $clog2(NDR);
  localparam int WORD_W = 16;
  localparam int CNT_W  = 6;
  localparam logic [3:0] DEV_ID = 4'b0101;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_RD_WCR = 3'd1,
    OP_WR_WCR = 3'd2,
    OP_RD_DR  = 3'd3,
    OP_WR_DR  = 3'd4,
    OP_RD_ST  = 3'd5,
    OP_DR2W   = 3'd6,
    OP_W2DR   = 3'd7
  } op_e;

  function automatic logic is_rd(op_e op);
    return (op == OP_RD_WCR) || (op == OP_RD_DR) || (op == OP_RD_ST);
  endfunction

  function automatic logic is_wr(op_e op);
    return (op == OP_WR_WCR) || (op == OP_WR_DR) || (op == OP_DR2W) || (op == OP_W2DR);
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(op_e op);
    return ((op == OP_DR2W) || (op == OP_W2DR)) ? CNT_W'(16) : CNT_W'(32);
  endfunction
endpackage

// File: rtl/dcp_spi_sync.sv
module dcp_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic cs_rise_o,
  output logic si_o
);
  // bit order {sck, cs_n, si}; idle value 3'b010
  logic [2:0] sync_q [STAGES];
  logic       sck_d_q, cs_d_q;
  logic [2:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= 3'b010;
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      sync_q[0] <= {sck_i, cs_ni, si_i};
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      sck_d_q <= sync_q[STAGES-1][2];
      cs_d_q  <= sync_q[STAGES-1][1];
    end
  end

  assign last       = sync_q[STAGES-1];
  assign sck_rise_o = last[2] & ~sck_d_q;
  assign sck_fall_o = ~last[2] & sck_d_q;
  assign cs_act_o   = ~last[1];
  assign cs_rise_o  = last[1] & ~cs_d_q;
  assign si_o       = last[0];
endmodule

// File: rtl/dcp_frame.sv
module dcp_frame
  import dcp_pkg::*;
#(
  parameter logic [3:0] DEV_ADDR = 4'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_act_i,
  input  logic              cs_rise_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output op_e               rd_op_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  output logic              cmd_vld_o,
  output op_e               cmd_op_o,
  output logic [SEL_W-1:0]  cmd_sel_o,
  output logic [WCR_W-1:0]  cmd_data_o,
  output logic              so_o,
  output logic              so_oe_o
);
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [7:0]        sh_q;
  logic [7:0]        byte_w;
  logic              id_ok_q;
  op_e               op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WCR_W-1:0]  data_q;
  logic [WORD_W-1:0] out_q;
  logic              oe_q;
  logic              cmd_vld_q;
  op_e               cmd_op_q;
  logic [SEL_W-1:0]  cmd_sel_q;
  logic [WCR_W-1:0]  cmd_data_q;

  assign byte_w = {sh_q[6:0], si_i};

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      sh_q      <= '0;
      id_ok_q   <= 1'b0;
      op_q      <= OP_NOP;
      sel_q     <= '0;
      data_q    <= '0;
    end else if (!cs_act_i) begin
      bit_cnt_q <= '0;
      id_ok_q   <= 1'b0;
      op_q      <= OP_NOP;
    end else if (sck_rise_i) begin
      sh_q <= byte_w;
      if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (bit_cnt_q == CNT_W'(7))
        id_ok_q <= (byte_w[7:4] == DEV_ID) && (byte_w[3:0] == DEV_ADDR);
      if (bit_cnt_q == CNT_W'(15)) begin
        op_q  <= op_e'(byte_w[7:5]);
        sel_q <= byte_w[SEL_W-1:0];
      end
      if ((bit_cnt_q >= CNT_W'(16)) && (bit_cnt_q < CNT_W'(32)))
        data_q <= {data_q[WCR_W-2:0], si_i};
    end
  end

  // commit on chip-select release, exact length only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_q  <= 1'b0;
      cmd_op_q   <= OP_NOP;
      cmd_sel_q  <= '0;
      cmd_data_q <= '0;
    end else begin
      cmd_vld_q <= cs_rise_i && id_ok_q && is_wr(op_q) && (bit_cnt_q == frame_len(op_q));
      if (cs_rise_i) begin
        cmd_op_q   <= op_q;
        cmd_sel_q  <= sel_q;
        cmd_data_q <= data_q;
      end
    end
  end

  // transmit path, shifts after SCK falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else if (!cs_act_i) begin
      oe_q <= 1'b0;
    end else if (sck_fall_i) begin
      if (id_ok_q && is_rd(op_q) && (bit_cnt_q == CNT_W'(16))) begin
        out_q <= rd_word_i;
        oe_q  <= 1'b1;
      end else if (oe_q) begin
        if (bit_cnt_q == CNT_W'(32)) oe_q <= 1'b0;
        else                         out_q <= {out_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign rd_op_o    = op_q;
  assign rd_sel_o   = sel_q;
  assign cmd_vld_o  = cmd_vld_q;
  assign cmd_op_o   = cmd_op_q;
  assign cmd_sel_o  = cmd_sel_q;
  assign cmd_data_o = cmd_data_q;
  assign so_o       = oe_q & out_q[WORD_W-1];
  assign so_oe_o    = oe_q;

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !so_oe_o); // R11
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (id_ok_q && is_rd(op_q))); // R2
  AST_CMD_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> $past(cs_rise_i)); // R9
endmodule

// File: rtl/dcp_regfile.sv
module dcp_regfile
  import dcp_pkg::*;
#(
  parameter int NV_CYC  = 2000,
  parameter int WRL_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  op_e               cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_sel_i,
  input  logic [WCR_W-1:0]  cmd_data_i,
  input  op_e               rd_op_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WCR_W-1:0]  wiper_o
);
  localparam int NV_W = $clog2(NV_CYC + 1);
  localparam int DL_W = $clog2(WRL_CYC + 1);

  logic [WCR_W-1:0] wcr_q, wiper_q, nv_dat_q, wcr_nxt;
  logic [WCR_W-1:0] dr_q [NDR];
  logic [SEL_W-1:0] nv_sel_q;
  logic [NV_W-1:0]  busy_q;
  logic [DL_W-1:0]  dly_q;
  logic             wip, acc, wcr_we, nv_start, nv_done;

  assign wip      = (busy_q != '0);
  assign acc      = cmd_vld_i && !wip;
  assign wcr_we   = acc && ((cmd_op_i == OP_WR_WCR) || (cmd_op_i == OP_DR2W));
  assign nv_start = acc && ((cmd_op_i == OP_WR_DR) || (cmd_op_i == OP_W2DR));
  assign nv_done  = (busy_q == NV_W'(1));
  assign wcr_nxt  = (cmd_op_i == OP_DR2W) ? dr_q[cmd_sel_i] : cmd_data_i;

  // volatile wiper counter and settling delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcr_q   <= '0;
      wiper_q <= '0;
      dly_q   <= '0;
    end else begin
      if (wcr_we) begin
        wcr_q <= wcr_nxt;
        dly_q <= DL_W'(WRL_CYC);
      end else if (dly_q != '0) begin
        dly_q <= dly_q - 1'b1;
      end
      if (!wcr_we && (dly_q == DL_W'(1))) wiper_q <= wcr_q;
    end
  end

  // nonvolatile write model
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= '0;
      nv_sel_q <= '0;
      nv_dat_q <= '0;
    end else if (nv_start) begin
      busy_q   <= NV_W'(NV_CYC);
      nv_sel_q <= cmd_sel_i;
      nv_dat_q <= (cmd_op_i == OP_W2DR) ? wcr_q : cmd_data_i;
    end else if (wip) begin
      busy_q <= busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NDR; i++) dr_q[i] <= '0;
    end else if (nv_done) begin
      for (int i = 0; i < NDR; i++)
        if (nv_sel_q == SEL_W'(i)) dr_q[i] <= nv_dat_q;
    end
  end

  always_comb begin
    rd_word_o = '0;
    case (rd_op_i)
      OP_RD_WCR: rd_word_o[WCR_W-1:0] = wcr_q;
      OP_RD_DR:  rd_word_o[WCR_W-1:0] = dr_q[rd_sel_i];
      OP_RD_ST:  rd_word_o[0]         = wip;
      default:   rd_word_o            = '0;
    endcase
  end

  assign wiper_o = wiper_q;

  AST_WIP_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> $past(cmd_vld_i)); // R5
  AST_BUSY_WCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && wip) |=> $stable(wcr_q)); // R10
  AST_WIPER_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0) |-> (wiper_q == wcr_q)); // R4
  AST_DR_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip && !nv_done) |=> $stable(dr_q[nv_sel_q])); // R5
endmodule

// File: rtl/dcp_spi_top.sv
module dcp_spi_top
  import dcp_pkg::*;
#(
  parameter int         NV_CYC   = 2000,
  parameter int         WRL_CYC  = 4,
  parameter logic [3:0] DEV_ADDR = 4'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             cs_ni,
  input  logic             si_i,
  output logic             so_o,
  output logic             so_oe_o,
  output logic [WCR_W-1:0] wiper_o
);
  logic              sck_rise, sck_fall, cs_act, cs_rise, si_s;
  logic [WORD_W-1:0] rd_word;
  op_e               rd_op, cmd_op;
  logic [SEL_W-1:0]  rd_sel, cmd_sel;
  logic              cmd_vld;
  logic [WCR_W-1:0]  cmd_data;

  dcp_spi_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni), .si_i(si_i),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_act_o(cs_act),
    .cs_rise_o(cs_rise), .si_o(si_s)
  );

  dcp_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_act_i(cs_act), .cs_rise_i(cs_rise), .si_i(si_s), .rd_word_i(rd_word),
    .rd_op_o(rd_op), .rd_sel_o(rd_sel), .cmd_vld_o(cmd_vld), .cmd_op_o(cmd_op),
    .cmd_sel_o(cmd_sel), .cmd_data_o(cmd_data), .so_o(so_o), .so_oe_o(so_oe_o)
  );

  dcp_regfile #(.NV_CYC(NV_CYC), .WRL_CYC(WRL_CYC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op),
    .cmd_sel_i(cmd_sel), .cmd_data_i(cmd_data), .rd_op_i(rd_op), .rd_sel_i(rd_sel),
    .rd_word_o(rd_word), .wiper_o(wiper_o)
  );
endmodule

// File: tb/sim_dcp_spi_top.sv
module sim_dcp_spi_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NV_WAIT = 2100;
  localparam int NV = 25;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [9:0] wiper;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcp_spi_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .wiper_o(wiper)
  );

  // frame, bits, compare?, expected reply, expected oe bits, post wait, requirement
  localparam logic [31:0] V_FRM [NV] = '{
    32'h5020_0000, 32'h5060_0000, 32'h5061_0000, 32'h5062_0000, 32'h5063_0000,
    32'h50A0_0000, 32'h5040_02A5, 32'h5020_0000, 32'h5081_0155, 32'h5061_0000,
    32'h6040_03FF, 32'h5020_0000, 32'h6020_0000, 32'h50E2_0000, 32'h5062_0000,
    32'h50C1_0000, 32'h5020_0000, 32'h5040_03FF, 32'h5020_0000, 32'h50C2_0000,
    32'h5020_0000, 32'h5000_03FF, 32'h5020_0000, 32'h5040_FC3A, 32'h5020_0000};
  localparam int V_NB [NV] = '{32,32,32,32,32, 32,32,32,32,32, 32,32,32,16,32,
                               16,32,24,32,24, 32,32,32,32,32};
  localparam bit V_CHK [NV] = '{1,1,1,1,1, 1,0,1,0,1, 0,1,1,0,1, 0,1,0,1,0, 1,0,1,0,1};
  localparam logic [15:0] V_EXP [NV] = '{
    16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h02A5, 16'h0, 16'h0155,
    16'h0, 16'h02A5, 16'h0, 16'h0, 16'h02A5, 16'h0, 16'h0155, 16'h0, 16'h0155, 16'h0,
    16'h0155, 16'h0, 16'h0155, 16'h0, 16'h003A};
  localparam int V_OE [NV] = '{16,16,16,16,16, 16,0,16,0,16, 0,16,0,0,16,
                               0,16,0,16,0, 16,0,16,0,16};
  localparam int V_WAIT [NV] = '{0,0,0,0,0, 0,0,0,NV_WAIT,0, 0,0,0,NV_WAIT,0,
                                 0,0,0,0,0, 0,0,0,0,0};
  // R1 reads, R3 write/read, R5 DR write, R2 bad id, R8 W2DR, R7 DR2W, R9 short frames, R11 nop, R3 padding
  localparam int V_REQ [NV] = '{1,1,1,1,1, 1,3,3,5,5, 2,2,2,8,8, 7,7,9,9,9, 9,11,11,3,3};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input int nb, input int post,
                           output logic [15:0] rd, output int oe_h, output int oe_r);
    rd = '0; oe_h = 0; oe_r = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      si = w[31-i];
      repeat (HALF) @(negedge clk);
      if (i < 16) oe_h += int'(so_oe);
      else begin
        oe_r += int'(so_oe);
        rd = {rd[14:0], so};
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (post) @(negedge clk);
  endtask

  task automatic do_frame(input logic [31:0] w, input int nb, input int post,
                          output logic [15:0] rd);
    int oh, orr;
    run_frame(w, nb, post, rd, oh, orr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int oh, orr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wiper", 16'(wiper), 16'h0);
    check("R1 so_oe", 16'(so_oe), 16'h0);

    for (int k = 0; k < NV; k++) begin
      run_frame(V_FRM[k], V_NB[k], 12 + V_WAIT[k], rd, oh, orr);
      if (V_CHK[k]) check($sformatf("R%0d vec%0d reply", V_REQ[k], k), rd, V_EXP[k]);
      // R11 output-enable window, R2 silent on bad id
      check($sformatf("R11 vec%0d oe_reply", k), 16'(orr), 16'(V_OE[k]));
      check($sformatf("R11 vec%0d oe_header", k), 16'(oh), 16'h0);
    end

    // R4 exact settling cycle
    do_frame(32'h5040_00F0, 32, 7, rd);
    check("R4 wiper before", 16'(wiper), 16'h003A);
    @(negedge clk);
    check("R4 wiper after", 16'(wiper), 16'h00F0);

    // R6, R10, R5 behaviour inside the busy window
    do_frame(32'h5083_00AA, 32, 12, rd);
    do_frame(32'h50A0_0000, 32, 12, rd);
    check("R6 wip busy", rd, 16'h0001);
    do_frame(32'h5040_03C3, 32, 12, rd);
    do_frame(32'h5063_0000, 32, 12, rd);
    check("R5 dr old while busy", rd, 16'h0000);
    repeat (NV_WAIT) @(negedge clk);
    do_frame(32'h50A0_0000, 32, 12, rd);
    check("R6 wip done", rd, 16'h0000);
    do_frame(32'h5063_0000, 32, 12, rd);
    check("R5 dr committed", rd, 16'h00AA);
    do_frame(32'h5020_0000, 32, 12, rd);
    check("R10 wcr unchanged", rd, 16'h00F0);
    check("R10 wiper unchanged", 16'(wiper), 16'h00F0);
    check("R11 oe idle", 16'(so_oe), 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule